// File: doc/BRIEF.md
# Nibble-Serial Output Link Transmitter

This block drives the transmit side of a four-bit output link that carries complex samples to a downstream receiver. It watches a sample-period strobe. When the receiver signals readiness at that strobe, the block captures one, two or four complex words from its input bus. It then shifts them out four bits at a time, paced by a bit clock that it derives from the system clock. Each complex word is a 16-bit in-phase part followed by a 16-bit quadrature part. Each word is sent as eight nibbles, most significant first.

The receiver paces the transfer through its ready line. A strobe that finds the receiver not ready is dropped. Between consecutive words, a not-ready receiver freezes the bit clock high until it becomes ready again. When the last nibble has gone out, the bit clock returns low and stays low until the next accepted strobe. A strobe that arrives while a transfer is still running is ignored and recorded on a sticky flag.

Top module: `nibble_link_tx`

## Requirements
- R1: A strobe that sees `rx_ready` low starts nothing: `link_clk` stays low and `link_data` stays 0 until a later strobe is accepted.
- R2: `word_mode` sampled at an accepted strobe sets the words sent: 0 sends word A, 1 sends A then B, 2 sends A, B, C, D in that order, and 3 acts as 0. Word A is `sample_bus[31:0]`, B is `[63:32]`, C is `[95:64]`, D is `[127:96]`.
- R3: Each word goes out as 8 nibbles, bits 31..28 first and bits 3..0 last, so that the in-phase half (bits 31:16) precedes the quadrature half. `link_data` changes only while `link_clk` is low and is stable through each high phase.
- R4: Every low phase and every high phase of `link_clk` lasts `clk_div`+1 system clocks, except a high phase stretched under R5.
- R5: At the end of the last nibble of a word that has a successor, `link_clk` stays high and `link_data` holds while `rx_ready` is low. `link_clk` falls one system clock after `rx_ready` is seen high.
- R6: After the high phase of the final nibble, `link_clk` falls without any ready check and stays low with `link_data` at 0 until the next accepted strobe.
- R7: All selected words are captured at the accepted strobe. Changes on `sample_bus` during a transfer do not alter the nibbles sent.
- R8: A strobe that arrives while a transfer is active is ignored and sets `overrun`. The flag stays set until reset.
- R9: After reset, `link_clk`, `link_data` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_strobe | input | 1 | One-cycle pulse marking the start of a sample period |
| word_mode | input | 2 | Number of words per transfer (0/3: one, 1: two, 2: four) |
| clk_div | input | DIVW | Bit-clock phase length minus one, in system clocks |
| rx_ready | input | 1 | Receiver ready; checked at the strobe and between words |
| sample_bus | input | 4*2*SW | Four complex words, A in the low 32 bits |
| link_clk | output | 1 | Generated bit clock |
| link_data | output | 4 | Nibble data, stable across each rising edge of `link_clk` |
| overrun | output | 1 | Sticky flag for a strobe that arrived during a transfer |

## Verification
The assertions assume that `clk_div` and `word_mode` stay constant from an accepted strobe until the transfer has finished. They also assume that a strobe is a single-cycle pulse. The stimulus changes mode and divisor only between transfers. It waits for the bit clock to settle low before the next strobe, except in the deliberate overrun case. Ready is dropped only at the rising edge of a word-final nibble, or at an idle strobe, so that each stall covers a word boundary.

// File: rtl/nibble_link_tx.sv
module nibble_link_tx #(
  parameter int SW   = 16,
  parameter int DIVW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_strobe,
  input  logic [1:0]        word_mode,
  input  logic [DIVW-1:0]   clk_div,
  input  logic              rx_ready,
  input  logic [8*SW-1:0]   sample_bus,
  output logic              link_clk,
  output logic [3:0]        link_data,
  output logic              overrun
);
  localparam int WW  = 2*SW;
  localparam int NIB = WW/4;
  localparam int NB  = $clog2(NIB);

  logic            active, hi;
  logic [DIVW-1:0] cnt;
  logic [NB-1:0]   nib;
  logic [1:0]      wleft;
  logic [4*WW-1:0] sh, ld;
  logic            phase_end, word_last;

  always_comb begin
    for (int i = 0; i < 4; i++) ld[(3-i)*WW +: WW] = sample_bus[i*WW +: WW];
  end

  assign phase_end = (cnt == clk_div);
  assign word_last = (nib == NB'(NIB-1));
  assign link_clk  = hi;
  assign link_data = active ? sh[4*WW-1 -: 4] : 4'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      hi      <= 1'b0;
      cnt     <= '0;
      nib     <= '0;
      wleft   <= '0;
      sh      <= '0;
      overrun <= 1'b0;
    end else if (!active) begin
      if (sample_strobe && rx_ready) begin
        active <= 1'b1;
        hi     <= 1'b0;
        cnt    <= '0;
        nib    <= '0;
        sh     <= ld;
        case (word_mode)
          2'd1:    wleft <= 2'd1;
          2'd2:    wleft <= 2'd3;
          default: wleft <= 2'd0;
        endcase
      end
    end else begin
      if (sample_strobe) overrun <= 1'b1;
      if (!phase_end) begin
        cnt <= cnt + 1'b1;
      end else if (!hi) begin
        hi  <= 1'b1;
        cnt <= '0;
      end else if (!word_last) begin
        nib <= nib + 1'b1;
        hi  <= 1'b0;
        cnt <= '0;
        sh  <= sh << 4;
      end else if (wleft == 2'd0) begin
        active <= 1'b0;
        hi     <= 1'b0;
        cnt    <= '0;
      end else if (rx_ready) begin
        nib   <= '0;
        wleft <= wleft - 1'b1;
        hi    <= 1'b0;
        cnt   <= '0;
        sh    <= sh << 4;
      end
    end
  end

  assert_idle_refused_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && sample_strobe && !rx_ready) |=> (!link_clk && link_data == 4'h0));

  assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_clk) |-> $stable(link_data));

  assert_boundary_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hi && phase_end && word_last && wleft != 2'd0 && !rx_ready)
      |=> (link_clk && $stable(link_data)));

  assert_end_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (!link_clk && link_data == 4'h0));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sample_strobe) |=> overrun);
endmodule

// File: tb/test_nibble_link_tx.sv
module test_nibble_link_tx;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0, rst_n = 0, sample_strobe = 0, rx_ready = 0;
  logic [1:0]   word_mode = 0;
  logic [7:0]   clk_div = 0;
  logic [127:0] sample_bus = '0;
  logic         link_clk, overrun;
  logic [3:0]   link_data;
  int           n_chk = 0, n_fail = 0;

  nibble_link_tx i_nibble_link_tx (
    .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe), .word_mode(word_mode),
    .clk_div(clk_div), .rx_ready(rx_ready), .sample_bus(sample_bus),
    .link_clk(link_clk), .link_data(link_data), .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int words_for(input logic [1:0] m);
    return (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
  endfunction

  function automatic logic [3:0] exp_nib(input logic [127:0] s, input int idx);
    logic [31:0] w;
    w = s[(idx/8)*32 +: 32];
    return w[31-4*(idx%8) -: 4];
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic idle_check(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      check("R6 idle clock", link_clk == 1'b0, int'(link_clk), 0);
      check("R6 idle data", link_data == 4'h0, int'(link_data), 0);
    end
  endtask

  task automatic xfer(input logic [1:0] m, input int d, input bit stall, input int ovr_at);
    logic [127:0] s;
    int nw, got, plen, stall_ctr;
    bit pb, started, stalling, stalled, done;
    logic [3:0] last;
    s = rnd128();
    nw = words_for(m);
    got = 0; plen = 0; stall_ctr = 0; pb = 0;
    started = 0; stalling = 0; stalled = 0; done = 0; last = 0;
    @(negedge clk);
    word_mode = m; clk_div = 8'(d); sample_bus = s; rx_ready = 1; sample_strobe = 1;
    @(negedge clk);
    sample_strobe = 0;
    sample_bus = rnd128();
    for (int c = 0; c < 5000 && !done; c++) begin
      if (c > 0) @(negedge clk);
      if (c == ovr_at) sample_strobe = 1;
      else sample_strobe = 0;
      if (link_clk != pb) begin
        if (link_clk) begin
          if (started)
            check("R4 low phase", plen == d + 1, plen, d + 1);
          check("R2/R3/R7 nibble", got < 8*nw && link_data == exp_nib(s, got),
                int'(link_data), int'(exp_nib(s, got)));
          last = link_data;
          got++;
          started = 1;
          if (stall && !stalled && got % 8 == 0 && got < 8*nw) begin
            rx_ready = 0; stall_ctr = d + 7; stalling = 1;
          end
        end else begin
          check(stalling ? "R5 stretched high" : "R4 high phase",
                plen == (stalling ? d + 7 : d + 1), plen, stalling ? d + 7 : d + 1);
          if (stalling) begin stalling = 0; stalled = 1; end
          if (got >= 8*nw) done = 1;
        end
        plen = 1;
      end else begin
        plen++;
        if (link_clk)
          check("R3/R5 data held high", link_data == last, int'(link_data), int'(last));
      end
      if (stall_ctr > 0) begin
        stall_ctr--;
        if (stall_ctr == 0) rx_ready = 1;
      end
      pb = link_clk;
    end
    sample_strobe = 0;
    check("R2 nibble count", got == 8*nw, got, 8*nw);
    check("R6 transfer finished", done, int'(done), 1);
    idle_check(d + 4);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    check("R9 reset clock", link_clk == 0, int'(link_clk), 0);
    check("R9 reset data", link_data == 0, int'(link_data), 0);
    check("R9 reset overrun", overrun == 0, int'(overrun), 0);
    rst_n = 1;
    idle_check(3);

    // R1: strobe while receiver not ready
    @(negedge clk); rx_ready = 0; sample_strobe = 1;
    @(negedge clk); sample_strobe = 0; rx_ready = 1;
    check("R1 no clock", link_clk == 0, int'(link_clk), 0);
    idle_check(20);

    // directed modes, including reserved mode 3 (R2)
    xfer(2'd0, 0, 0, -1);
    xfer(2'd1, 1, 0, -1);
    xfer(2'd2, 0, 0, -1);
    xfer(2'd3, 2, 0, -1);
    // word boundary stalls (R5)
    xfer(2'd1, 0, 1, -1);
    xfer(2'd2, 3, 1, -1);
    check("R8 no overrun yet", overrun == 0, int'(overrun), 0);

    // random mix
    for (int t = 0; t < 24; t++) begin
      logic [1:0] m;
      int d;
      bit st;
      m = 2'($urandom_range(0, 3));
      d = $urandom_range(0, 5);
      st = 1'($urandom_range(0, 1));
      xfer(m, d, st, -1);
    end
    check("R8 still clear", overrun == 0, int'(overrun), 0);

    // R8: strobe in mid-transfer is ignored and flagged
    xfer(2'd2, 1, 0, 12);
    check("R8 overrun set", overrun == 1, int'(overrun), 1);
    xfer(2'd1, 0, 0, -1);
    check("R8 overrun sticky", overrun == 1, int'(overrun), 1);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check("R9 overrun cleared by reset", overrun == 0, int'(overrun), 0);
    xfer(2'd0, 4, 0, -1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule